// File: doc/BRIEF.md
# Flash Memory Controller Model

This block stands in for an embedded flash macro and its controller, built entirely from synthesizable storage so that a system can run without an external flash model. One memory-mapped word bus reaches three things: a main storage array organised in pages, a small separate configuration region, and a set of control registers. Software programs the storage the way it would program real flash. It first selects an operating mode, then writes words or issues erase commands, and then returns the mode to read-only.

A two-bit mode register decides what a bus write can do. In write mode, word writes into either storage region are committed. In erase mode, the erase command registers act. Three erase commands exist: clear one page of the main array, given as any word address inside it; clear the entire main array; clear the entire configuration region. An erased word reads as all ones. The ready status is always set, because every command finishes in a single cycle. Reads of storage work in every mode. Every access gets a registered response one cycle later, and an access to an unmapped address gets a bus error.

Top module: `flash_ctl`

## Requirements
- R1: After reset, every word of the main array and of the configuration region reads all ones, the mode register reads 0, and rsp_valid is low.
- R2: The mode register sits at register offset 1 and holds wdata[1:0]. It reads back the last value written, including 3. The encodings are 0 read-only, 1 write, 2 erase, and 3 no write and no erase.
- R3: The ready register at register offset 0 always reads 1. A write to it is accepted without error and has no effect.
- R4: A word write to the main array or to the configuration region is committed only in mode 1, and a later read returns the written value. In modes 0, 2 and 3 the write is ignored and the word keeps its previous contents.
- R5: Each access with req high gets exactly one response cycle, with rsp_valid high on the cycle after the request. Read data is valid in that cycle in every mode.
- R6: In mode 2, writing a main-array word address to register offset 2 or to register offset 3 sets all PAGE_WORDS words of the page holding that address to all ones. The page is address/PAGE_WORDS. Other pages are not touched. An address at or beyond the end of the main array is ignored.
- R7: In mode 2, writing exactly 1 to register offset 4 sets every main-array word to all ones and leaves the configuration region unchanged.
- R8: In mode 2, writing exactly 1 to register offset 5 sets every configuration word to all ones and leaves the main array unchanged.
- R9: Writes to register offsets 2 to 5 are ignored outside mode 2. Writes of a value other than 1 to offsets 4 and 5 are also ignored.
- R10: An access to an unmapped word address returns rsp_err = 1 with rsp_rdata = 0. This covers addresses past the main array, past the configuration region, or past register offset 5.
- R11: The address map is as follows. The main array is at word addresses 0 to PAGE_WORDS*NUM_PAGES-1. The configuration region starts at CFG_BASE. The registers start at REG_BASE. Register offsets 2 to 5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write access, 0 = read access |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data; 0 for writes and errors |
| rsp_err | output | 1 | Unmapped access |

## Verification
Each storage word has a hidden written/erased flag. A flag that clears at the wrong time shows up as an unexpected all-ones word on the very next read of that address. A flag that fails to clear shows up as stale data surviving an erase. A wrong mode value shows up through its read-back, and indirectly as writes or erases taking or not taking effect. The bench therefore reads the word at each page edge right after every erase, and reads it back after every gated write. Any wrong state appears in the response one cycle after the read is issued.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_ERASE = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RGN_MAIN = 2'd0,
    RGN_CFG  = 2'd1,
    RGN_REG  = 2'd2,
    RGN_NONE = 2'd3
  } region_e;

  // Register offsets from the register base (word addresses).
  localparam int unsigned OFS_READY  = 0;
  localparam int unsigned OFS_MODE   = 1;
  localparam int unsigned OFS_PAGE_A = 2;
  localparam int unsigned OFS_PAGE_B = 3;
  localparam int unsigned OFS_ALL    = 4;
  localparam int unsigned OFS_CFGCLR = 5;
  localparam int unsigned REG_COUNT  = 6;

  // True when a lies in [base, base+size).
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    return (a >= base) && (a < base + size);
  endfunction

  // Page number of a word address, for power-of-two page sizes.
  function automatic logic [31:0] page_of(input logic [31:0] word_addr,
                                          input int unsigned shift);
    return word_addr >> shift;
  endfunction

endpackage

// File: rtl/fmc_decode.sv
module fmc_decode
  import fmc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned MAIN_WORDS = 2048,
  parameter int unsigned CFG_WORDS  = 64,
  parameter logic [31:0] CFG_BASE   = 32'h1000,
  parameter logic [31:0] REG_BASE   = 32'h2000,
  localparam int unsigned MAIN_AW   = $clog2(MAIN_WORDS),
  localparam int unsigned CFG_AW    = $clog2(CFG_WORDS)
) (
  input  logic [ADDR_W-1:0]  addr,
  output region_e            region,
  output logic [MAIN_AW-1:0] main_idx,
  output logic [CFG_AW-1:0]  cfg_idx,
  output logic [2:0]         reg_ofs
);

  logic [31:0] a32;
  assign a32 = 32'(addr);

  // R11: fixed window order, main first.
  always_comb begin
    if (in_window(a32, 32'd0, MAIN_WORDS))
      region = RGN_MAIN;
    else if (in_window(a32, CFG_BASE, CFG_WORDS))
      region = RGN_CFG;
    else if (in_window(a32, REG_BASE, REG_COUNT))
      region = RGN_REG;
    else
      region = RGN_NONE;  // R10
  end

  assign main_idx = MAIN_AW'(a32);
  assign cfg_idx  = CFG_AW'(a32 - CFG_BASE);
  assign reg_ofs  = 3'(a32 - REG_BASE);

endmodule

// File: rtl/fmc_store.sv
module fmc_store #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned WORDS      = 2048,
  parameter int unsigned PAGE_WORDS = 8,
  localparam int unsigned NPAGES    = WORDS / PAGE_WORDS,
  localparam int unsigned IDX_W     = $clog2(WORDS),
  localparam int unsigned PG_W      = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pg_erase,
  input  logic [PG_W-1:0]   pg_idx,
  input  logic              all_erase,
  output logic [DATA_W-1:0] rd_data
);

  // Data words carry no reset; a per-word flag says whether a word holds
  // programmed data (1) or reads as erased (0).
  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  valid_q;
  logic [WORDS-1:0]  clr_mask;
  logic [WORDS-1:0]  set_mask;
  logic [WORDS-1:0]  valid_d;

  for (genvar p = 0; p < NPAGES; p++) begin : g_page_clear
    logic hit;
    assign hit = all_erase || (pg_erase && (pg_idx == PG_W'(p)));
    assign clr_mask[p*PAGE_WORDS +: PAGE_WORDS] = {PAGE_WORDS{hit}};
  end

  assign set_mask = wr_en ? (WORDS'(1) << idx) : '0;
  assign valid_d  = (valid_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;  // R1: everything reads erased
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  assign rd_data = valid_q[idx] ? mem[idx] : '1;

  // R4: a committed write makes its word readable next cycle
  a_r4_write_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(idx)]);

  // R7: a full clear with no write leaves nothing programmed
  a_r7_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (all_erase && !wr_en) |=> (valid_q == '0));

  // R9: programmed flags only fall on an erase command
  a_r9_no_stray_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_erase && !all_erase) |=> ((valid_q & $past(valid_q)) == $past(valid_q)));

endmodule

// File: rtl/fmc_ctrl.sv
module fmc_ctrl
  import fmc_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PAGE_WORDS = 8,
  parameter int unsigned NUM_PAGES  = 256,
  localparam int unsigned MAIN_WORDS = PAGE_WORDS * NUM_PAGES,
  localparam int unsigned PAGE_SHIFT = $clog2(PAGE_WORDS),
  localparam int unsigned PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_ofs,
  input  logic [DATA_W-1:0] wdata,
  output mode_e             mode,
  output logic              store_wr_ok,
  output logic              pg_erase,
  output logic [PG_W-1:0]   pg_idx,
  output logic              main_clear,
  output logic              cfg_clear,
  output logic [DATA_W-1:0] reg_rdata
);

  mode_e mode_q;
  logic  mode_wr;
  logic  erase_ok;
  logic  is_one;
  logic  addr_in_main;

  assign mode_wr = reg_wr && (reg_ofs == 3'(OFS_MODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_READ;       // R1
    else if (mode_wr) mode_q <= mode_e'(wdata[1:0]);  // R2
  end

  assign mode        = mode_q;
  assign store_wr_ok = (mode_q == MODE_WRITE);   // R4
  assign erase_ok    = (mode_q == MODE_ERASE);   // R9
  assign is_one      = (wdata == DATA_W'(1));
  assign addr_in_main = (wdata < DATA_W'(MAIN_WORDS));

  // R6: two equivalent page-erase registers
  assign pg_erase   = reg_wr && erase_ok && addr_in_main &&
                      ((reg_ofs == 3'(OFS_PAGE_A)) || (reg_ofs == 3'(OFS_PAGE_B)));
  assign pg_idx     = PG_W'(page_of(32'(wdata), PAGE_SHIFT));
  assign main_clear = reg_wr && erase_ok && is_one && (reg_ofs == 3'(OFS_ALL));    // R7
  assign cfg_clear  = reg_wr && erase_ok && is_one && (reg_ofs == 3'(OFS_CFGCLR)); // R8

  always_comb begin
    unique case (reg_ofs)
      3'(OFS_READY): reg_rdata = DATA_W'(1);     // R3
      3'(OFS_MODE):  reg_rdata = DATA_W'(mode_q);
      default:       reg_rdata = '0;             // R11: commands read zero
    endcase
  end

  // R2: mode changes only on a mode-register write
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));

  // R2: a mode write lands next cycle
  a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q == mode_e'($past(wdata[1:0]))));

  // R9: at most one erase command per cycle
  a_r9_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pg_erase, main_clear, cfg_clear}));

endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
  import fmc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PAGE_WORDS = 8,
  parameter int unsigned NUM_PAGES  = 256,
  parameter int unsigned CFG_WORDS  = 64,
  parameter logic [31:0] CFG_BASE   = 32'h1000,
  parameter logic [31:0] REG_BASE   = 32'h2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  localparam int unsigned MAIN_WORDS = PAGE_WORDS * NUM_PAGES;
  localparam int unsigned MAIN_AW    = $clog2(MAIN_WORDS);
  localparam int unsigned CFG_AW     = $clog2(CFG_WORDS);
  localparam int unsigned PG_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  region_e             region;
  logic [MAIN_AW-1:0]  main_idx;
  logic [CFG_AW-1:0]   cfg_idx;
  logic [2:0]          reg_ofs;
  mode_e               mode;
  logic                store_wr_ok;
  logic                pg_erase;
  logic [PG_W-1:0]     pg_idx;
  logic                main_clear;
  logic                cfg_clear;
  logic [DATA_W-1:0]   reg_rdata;
  logic [DATA_W-1:0]   main_rdata;
  logic [DATA_W-1:0]   cfg_rdata;
  logic [DATA_W-1:0]   rd_mux;

  // Named internal events
  logic reg_wr, main_we, cfg_we;
  assign reg_wr  = req && we && (region == RGN_REG);
  assign main_we = req && we && (region == RGN_MAIN) && store_wr_ok;
  assign cfg_we  = req && we && (region == RGN_CFG)  && store_wr_ok;

  fmc_decode #(
    .ADDR_W(ADDR_W), .MAIN_WORDS(MAIN_WORDS), .CFG_WORDS(CFG_WORDS),
    .CFG_BASE(CFG_BASE), .REG_BASE(REG_BASE)
  ) u_decode (
    .addr(addr), .region(region), .main_idx(main_idx),
    .cfg_idx(cfg_idx), .reg_ofs(reg_ofs)
  );

  fmc_ctrl #(
    .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS), .NUM_PAGES(NUM_PAGES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ofs(reg_ofs),
    .wdata(wdata), .mode(mode), .store_wr_ok(store_wr_ok),
    .pg_erase(pg_erase), .pg_idx(pg_idx), .main_clear(main_clear),
    .cfg_clear(cfg_clear), .reg_rdata(reg_rdata)
  );

  fmc_store #(
    .DATA_W(DATA_W), .WORDS(MAIN_WORDS), .PAGE_WORDS(PAGE_WORDS)
  ) u_main (
    .clk(clk), .rst_n(rst_n), .wr_en(main_we), .idx(main_idx),
    .wr_data(wdata), .pg_erase(pg_erase), .pg_idx(pg_idx),
    .all_erase(main_clear), .rd_data(main_rdata)
  );

  // Configuration region: a single page, cleared only as a whole (R8).
  fmc_store #(
    .DATA_W(DATA_W), .WORDS(CFG_WORDS), .PAGE_WORDS(CFG_WORDS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .idx(cfg_idx),
    .wr_data(wdata), .pg_erase(1'b0), .pg_idx(1'b0),
    .all_erase(cfg_clear), .rd_data(cfg_rdata)
  );

  always_comb begin
    unique case (region)
      RGN_MAIN: rd_mux = main_rdata;
      RGN_CFG:  rd_mux = cfg_rdata;
      RGN_REG:  rd_mux = reg_rdata;
      default:  rd_mux = '0;  // R10
    endcase
  end

  // R5: single registered response stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req;
      rsp_rdata <= (req && !we) ? rd_mux : '0;
      rsp_err   <= req && (region == RGN_NONE);
    end
  end

  // R5: one response per request, one cycle later
  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid);

  // R10: an error response never carries data
  a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  // R3: the ready register always answers 1
  a_r3_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && (region == RGN_REG) && (reg_ofs == 3'(OFS_READY)))
      |=> (rsp_rdata == DATA_W'(1)));

  // R4: storage is never committed outside write mode
  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (main_we || cfg_we) |-> (mode == MODE_WRITE));

endmodule

// File: tb/test_flash_ctl.sv
module test_flash_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  always #5 clk = ~clk;  // 100 MHz

  flash_ctl i_flash_ctl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  int checks = 0;
  int failures = 0;

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  localparam logic [15:0] RMODE = 16'h2001;

  typedef struct packed {
    logic        w;
    logic [15:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic        err;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h2000, 32'h0,         32'h1,         1'b0, 8'd3},  // R3 ready
    '{1'b0, 16'h2001, 32'h0,         32'h0,         1'b0, 8'd1},  // R1 mode 0
    '{1'b1, 16'h2001, 32'h3,         32'h0,         1'b0, 8'd2},  // R2
    '{1'b0, 16'h2001, 32'h0,         32'h3,         1'b0, 8'd2},
    '{1'b1, 16'h2001, 32'h0,         32'h0,         1'b0, 8'd2},
    '{1'b0, 16'h2001, 32'h0,         32'h0,         1'b0, 8'd2},
    '{1'b1, 16'h0010, 32'h1234,      32'h0,         1'b0, 8'd4},  // R4 ignored
    '{1'b0, 16'h0010, 32'h0,         ONES,          1'b0, 8'd4},
    '{1'b1, 16'h2001, 32'h1,         32'h0,         1'b0, 8'd2},
    '{1'b1, 16'h0010, 32'hA5A5_0001, 32'h0,         1'b0, 8'd4},
    '{1'b1, 16'h0017, 32'h7,         32'h0,         1'b0, 8'd4},
    '{1'b1, 16'h0018, 32'h8,         32'h0,         1'b0, 8'd4},
    '{1'b1, 16'h1000, 32'hC0,        32'h0,         1'b0, 8'd4},
    '{1'b1, 16'h103F, 32'hCF,        32'h0,         1'b0, 8'd4},
    '{1'b0, 16'h0010, 32'h0,         32'hA5A5_0001, 1'b0, 8'd4},
    '{1'b0, 16'h1000, 32'h0,         32'hC0,        1'b0, 8'd11}, // R11
    '{1'b1, 16'h2002, 32'h10,        32'h0,         1'b0, 8'd9},  // R9
    '{1'b0, 16'h0010, 32'h0,         32'hA5A5_0001, 1'b0, 8'd9},
    '{1'b1, 16'h2001, 32'h2,         32'h0,         1'b0, 8'd2},
    '{1'b1, 16'h0011, 32'h55,        32'h0,         1'b0, 8'd4},
    '{1'b0, 16'h0011, 32'h0,         ONES,          1'b0, 8'd4},
    '{1'b1, 16'h2002, 32'h13,        32'h0,         1'b0, 8'd6},  // R6 page 2
    '{1'b0, 16'h0010, 32'h0,         ONES,          1'b0, 8'd6},
    '{1'b0, 16'h0017, 32'h0,         ONES,          1'b0, 8'd6},
    '{1'b0, 16'h0018, 32'h0,         32'h8,         1'b0, 8'd6},
    '{1'b1, 16'h2003, 32'h800,       32'h0,         1'b0, 8'd6},
    '{1'b0, 16'h0018, 32'h0,         32'h8,         1'b0, 8'd6},
    '{1'b1, 16'h2004, 32'h2,         32'h0,         1'b0, 8'd9},
    '{1'b0, 16'h0018, 32'h0,         32'h8,         1'b0, 8'd9},
    '{1'b1, 16'h2005, 32'h0,         32'h0,         1'b0, 8'd9},
    '{1'b0, 16'h1000, 32'h0,         32'hC0,        1'b0, 8'd9},
    '{1'b1, 16'h2004, 32'h1,         32'h0,         1'b0, 8'd7},  // R7
    '{1'b0, 16'h0018, 32'h0,         ONES,          1'b0, 8'd7},
    '{1'b0, 16'h103F, 32'h0,         32'hCF,        1'b0, 8'd7},
    '{1'b1, 16'h2005, 32'h1,         32'h0,         1'b0, 8'd8},  // R8
    '{1'b0, 16'h103F, 32'h0,         ONES,          1'b0, 8'd8},
    '{1'b0, 16'h3000, 32'h0,         32'h0,         1'b1, 8'd10}, // R10
    '{1'b1, 16'h1040, 32'h5,         32'h0,         1'b1, 8'd10},
    '{1'b0, 16'h0800, 32'h0,         32'h0,         1'b1, 8'd10},
    '{1'b0, 16'h2004, 32'h0,         32'h0,         1'b0, 8'd11},
    '{1'b0, 16'h2006, 32'h0,         32'h0,         1'b1, 8'd10},
    '{1'b1, 16'h2000, 32'h0,         32'h0,         1'b0, 8'd3},
    '{1'b0, 16'h2000, 32'h0,         32'h1,         1'b0, 8'd3}
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // One access: drive at a falling edge, sample the response one cycle later.
  task automatic bus(input logic w, input logic [15:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic e, output logic v);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd = rsp_rdata; e = rsp_err; v = rsp_valid;
  endtask

  task automatic op(input logic w, input logic [15:0] a, input logic [31:0] d,
                    input logic [31:0] exp, input logic experr, input int rq);
    logic [31:0] rd;
    logic e, v;
    bus(w, a, d, rd, e, v);
    check(v == 1'b1, 5, "R5 rsp_valid", 32'(v), 32'h1);
    check(e == experr, rq, "rsp_err", 32'(e), 32'(experr));
    if (!w) check(rd == exp, rq, "rsp_rdata", rd, exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: response idle while in reset
    check(rsp_valid == 1'b0, 1, "reset rsp_valid", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    // R1: reset contents
    op(1'b0, 16'h0000, 0, ONES, 1'b0, 1);
    op(1'b0, 16'h07FF, 0, ONES, 1'b0, 1);
    op(1'b0, 16'h1020, 0, ONES, 1'b0, 1);

    for (int i = 0; i < NV; i++)
      op(VEC[i].w, VEC[i].a, VEC[i].d, VEC[i].exp, VEC[i].err, int'(VEC[i].rq));

    // R6: second page-erase register, and last page boundary
    op(1'b1, RMODE, 32'h1, 0, 1'b0, 2);
    op(1'b1, 16'h0010, 32'h22, 0, 1'b0, 4);
    op(1'b1, 16'h07FF, 32'h99, 0, 1'b0, 4);
    op(1'b1, 16'h07F7, 32'h77, 0, 1'b0, 4);
    op(1'b1, RMODE, 32'h2, 0, 1'b0, 2);
    op(1'b1, 16'h2003, 32'h14, 0, 1'b0, 6);
    op(1'b0, 16'h0010, 0, ONES, 1'b0, 6);
    op(1'b1, 16'h2002, 32'h7F8, 0, 1'b0, 6);
    op(1'b0, 16'h07FF, 0, ONES, 1'b0, 6);
    op(1'b0, 16'h07F7, 0, 32'h77, 1'b0, 6);

    // R4 / R2: mode 3 blocks writes and erases
    op(1'b1, RMODE, 32'h3, 0, 1'b0, 2);
    op(1'b1, 16'h0020, 32'h5A, 0, 1'b0, 4);
    op(1'b0, 16'h0020, 0, ONES, 1'b0, 4);
    op(1'b1, 16'h2004, 32'h1, 0, 1'b0, 9);
    op(1'b0, 16'h07F7, 0, 32'h77, 1'b0, 9);

    // R5: exactly one response cycle, none when idle
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 16'h2000;
    @(negedge clk);
    req = 1'b0;
    check(rsp_valid == 1'b1, 5, "response cycle", 32'(rsp_valid), 32'h1);
    @(negedge clk);
    check(rsp_valid == 1'b0, 5, "idle after response", 32'(rsp_valid), 32'h0);

    // R1: reset in the middle clears storage flags and mode
    op(1'b1, RMODE, 32'h1, 0, 1'b0, 2);
    op(1'b1, 16'h0030, 32'h5, 0, 1'b0, 4);
    op(1'b0, 16'h0030, 0, 32'h5, 1'b0, 4);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    op(1'b0, 16'h0030, 0, ONES, 1'b0, 1);
    op(1'b0, RMODE, 0, 32'h0, 1'b0, 1);

    finish_run();
  end

endmodule